// File: doc/BRIEF.md
# Packed SIMD Integer Lane ALU

This block is a 128-bit packed arithmetic unit. It splits both operands into independent lanes and works on each lane on its own. The lane width is chosen per request: 8, 16 or 32 bits. No carry, borrow or product bit ever passes from one lane into the next.

It offers wrapping add, subtract and low-half multiply. It has two mask-producing predicates, equality and non-zero AND, which set a lane to all ones or all zeros. It also has two's-complement absolute value and negate. Four more forms ignore the lane size: two sign-bit operations on 32-bit float words, a full-width NOT and a full-width XOR.

The lane logic is purely combinational. A thin registered shell around it takes one request per cycle when `in_valid` is high. One cycle later it presents the result with `out_valid`. A request that cannot be carried out returns a zero result with `illegal` raised. This covers a lane operation with size code 3, and any operation code the unit does not define.

Top module: `simd_lane_alu`

## Requirements
- R1: While and after reset (synchronous, active high), `out_valid`, `illegal` and `result` are all zero until the first accepted request.
- R2: A request sampled with `in_valid` high appears on `result`/`illegal` with `out_valid` high exactly one cycle later. With `in_valid` low, `out_valid` falls the next cycle and `result` and `illegal` hold their last values.
- R3: `lane_size` selects the lane layout. Code 0 gives sixteen 8-bit lanes, code 1 gives eight 16-bit lanes and code 2 gives four 32-bit lanes. Lane k occupies bits [k*w +: w].
- R4: Operation 0 (add) and operation 1 (subtract, a minus b) keep the low w bits of each lane result. They wrap modulo 2^w with no carry or borrow into the next lane.
- R5: Operation 2 (multiply) returns the low w bits of the per-lane product.
- R6: Operation 3 (equality) sets a lane to all ones when the two input lanes are equal, otherwise to zero.
- R7: Operation 4 (bit test) sets a lane to all ones when the AND of the two input lanes is non-zero, otherwise to zero.
- R8: Operation 5 (absolute value) and operation 6 (negate) treat lane a as two's complement. `b` is unused. The most negative lane value maps to itself.
- R9: Operation 7 clears and operation 8 inverts bit 31 of every 32-bit word of `a`. All other bits pass unchanged, and `lane_size` has no effect, code 3 included.
- R10: Operation 9 returns the inverse of all 128 bits of `a`. Operation 10 returns `a` XOR `b` over the full width. Neither depends on `lane_size`, code 3 included.
- R11: A lane operation (codes 0 to 6) with `lane_size` 3 returns a zero result with `illegal` high.
- R12: Operation codes 11 to 15 return a zero result with `illegal` high. Every defined, legal request returns with `illegal` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 4 | Operation code |
| lane_size | input | 2 | Lane width code |
| opnd_a | input | 128 | First operand |
| opnd_b | input | 128 | Second operand |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 128 | Registered result |
| illegal | output | 1 | Request could not be carried out |

## Verification
Arithmetic runs at each lane width with all-ones lanes plus one, and with zero minus one. These patterns make a carry or borrow that leaks across a lane edge show up at once, and they tell each width's lane boundaries apart. The predicates get lane patterns where some lanes match and some do not, so a swapped or shifted mask is visible. Absolute value and negate get the most negative value and ordinary negatives at each width. The size-independent forms are driven with size code 3 to show the code is ignored there. Illegal sizes and undefined codes are sent back-to-back with legal requests, and an idle gap afterwards shows that the result holds.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_EQ   = 4'd3,
    OP_TST  = 4'd4,
    OP_IABS = 4'd5,
    OP_INEG = 4'd6,
    OP_FABS = 4'd7,
    OP_FNEG = 4'd8,
    OP_NOT  = 4'd9,
    OP_XOR  = 4'd10
  } simd_op_e;

  localparam logic [1:0] SIZE_BAD = 2'd3;

  function automatic logic is_lane_op(input logic [3:0] op);
    return op <= 4'd6;
  endfunction

endpackage

// File: rtl/simd_lane_slice.sv
module simd_lane_slice #(
  parameter int LANE_W = 8
) (
  input  logic [3:0]        op,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] y
);
  import simd_alu_pkg::*;

  localparam logic [LANE_W-1:0] ONE = {{(LANE_W-1){1'b0}}, 1'b1};

  logic [LANE_W-1:0] neg_a;
  assign neg_a = ~a + ONE;

  always_comb begin
    y = '0;
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = a * b;
      OP_EQ:   y = (a == b) ? '1 : '0;
      OP_TST:  y = ((a & b) != '0) ? '1 : '0;
      OP_IABS: y = a[LANE_W-1] ? neg_a : a;
      OP_INEG: y = neg_a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/simd_lane_core.sv
module simd_lane_core #(
  parameter int DATA_W = 128,
  parameter int FP_W   = 32
) (
  input  logic [3:0]        op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              illegal
);
  import simd_alu_pkg::*;

  localparam int NUM_SIZES = 3;
  localparam int FP_WORDS  = DATA_W / FP_W;

  function automatic logic [DATA_W-1:0] make_sign_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < FP_WORDS; i++) m[i*FP_W + FP_W - 1] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] SIGN_MASK = make_sign_mask();

  logic [NUM_SIZES-1:0][DATA_W-1:0] by_size;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LW = 8 << s;
    localparam int NL = DATA_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      simd_lane_slice #(.LANE_W(LW)) u_slice (
        .op (op),
        .a  (a[l*LW +: LW]),
        .b  (b[l*LW +: LW]),
        .y  (by_size[s][l*LW +: LW])
      );
    end
  end

  always_comb begin
    y       = '0;
    illegal = 1'b0;
    if (is_lane_op(op)) begin
      case (size)
        2'd0:    y = by_size[0];
        2'd1:    y = by_size[1];
        2'd2:    y = by_size[2];
        default: illegal = 1'b1;
      endcase
    end else begin
      case (op)
        OP_FABS: y = a & ~SIGN_MASK;
        OP_FNEG: y = a ^ SIGN_MASK;
        OP_NOT:  y = ~a;
        OP_XOR:  y = a ^ b;
        default: illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int DATA_W = 128,
  parameter int FP_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op_sel,
  input  logic [1:0]        lane_size,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  logic [DATA_W-1:0] core_y;
  logic              core_bad;

  simd_lane_core #(.DATA_W(DATA_W), .FP_W(FP_W)) u_core (
    .op      (op_sel),
    .size    (lane_size),
    .a       (opnd_a),
    .b       (opnd_b),
    .y       (core_y),
    .illegal (core_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= core_y;
        illegal <= core_bad;
      end
    end
  end
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        op_sel,
  input logic [1:0]        lane_size,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              illegal
);
  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  valid_drops_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(illegal)));
  // R11
  bad_size_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel <= 4'd6 && lane_size == 2'd3) |=> (illegal && result == '0));
  // R12
  bad_op_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel >= 4'd11) |=> (illegal && result == '0));
  // R10
  not_full_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 4'd9) |=> (result == ~$past(opnd_a) && !illegal));
  // R10
  xor_full_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 4'd10) |=> (result == ($past(opnd_a) ^ $past(opnd_b))));
  // R9
  fabs_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 4'd7) |=> (!result[31] && !result[63] && !result[95] && !result[127]));
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
  .lane_size(lane_size), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .out_valid(out_valid), .result(result), .illegal(illegal)
);

// File: tb/tb_simd_lane_alu.sv
`timescale 1ns/1ps
module tb_simd_lane_alu;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   op_sel = '0;
  logic [1:0]   lane_size = '0;
  logic [127:0] opnd_a = '0;
  logic [127:0] opnd_b = '0;
  logic         out_valid;
  logic [127:0] result;
  logic         illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [128:0] exp_q[$];
  string        tag_q[$];
  logic [128:0] last_exp = '0;

  always #2.5 clk = ~clk;

  simd_lane_alu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .lane_size(lane_size), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  function automatic logic [128:0] model(input logic [3:0] op, input logic [1:0] sz,
                                         input logic [127:0] a, input logic [127:0] b);
    logic [127:0] res;
    logic [127:0] sm;
    int lw;
    logic [31:0] m, x, y, r;
    res = '0;
    sm  = {4{32'h8000_0000}};
    if (op >= 4'd11) return {1'b1, 128'b0};
    if (op == 4'd7) return {1'b0, a & ~sm};
    if (op == 4'd8) return {1'b0, a ^ sm};
    if (op == 4'd9) return {1'b0, ~a};
    if (op == 4'd10) return {1'b0, a ^ b};
    if (sz == 2'd3) return {1'b1, 128'b0};
    lw = 8 << sz;
    m  = (lw == 32) ? 32'hFFFF_FFFF : ((32'h1 << lw) - 32'h1);
    for (int i = 0; i < 128 / lw; i++) begin
      x = 32'(a >> (i * lw)) & m;
      y = 32'(b >> (i * lw)) & m;
      case (op)
        4'd0: r = (x + y) & m;
        4'd1: r = (x - y) & m;
        4'd2: r = (x * y) & m;
        4'd3: r = (x == y) ? m : 32'h0;
        4'd4: r = ((x & y) != 0) ? m : 32'h0;
        4'd5: r = x[lw-1] ? ((~x + 32'h1) & m) : x;
        default: r = (~x + 32'h1) & m;
      endcase
      res = res | ({96'b0, r} << (i * lw));
    end
    return {1'b0, res};
  endfunction

  task automatic send(input logic [3:0] op, input logic [1:0] sz,
                      input logic [127:0] a, input logic [127:0] b, input string tag);
    @(negedge clk);
    op_sel = op; lane_size = sz; opnd_a = a; opnd_b = b; in_valid = 1'b1;
    exp_q.push_back(model(op, sz, a, b));
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected out_valid: actual 1 expected 0");
      end else begin
        logic [128:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        if ({illegal, result} !== e) begin
          fails++;
          $display("FAIL %s actual ill=%0b res=%h expected ill=%0b res=%h",
                   t, illegal, result, e[128], e[127:0]);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (out_valid !== 1'b0 || illegal !== 1'b0 || result !== '0) begin
      fails++;
      $display("FAIL R1 actual v=%0b ill=%0b res=%h expected 0 0 0", out_valid, illegal, result);
    end
    @(negedge clk); rst = 1'b0;
    // R4 R3 carry must not cross lanes at each width
    send(4'd0, 2'd0, {16{8'hFF}}, {16{8'h01}}, "R4 add8");
    send(4'd0, 2'd1, {8{16'hFFFF}}, {8{16'h0001}}, "R4 add16");
    send(4'd0, 2'd2, {4{32'hFFFF_FFFF}}, {4{32'h1}}, "R4 add32");
    send(4'd0, 2'd1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'h1111_2222_3333_4444_5555_6666_7777_8888, "R3 add16 mixed");
    send(4'd1, 2'd0, '0, {16{8'h01}}, "R4 sub8 borrow");
    send(4'd1, 2'd2, 128'h5, 128'h6, "R4 sub32");
    // R5
    send(4'd2, 2'd0, {16{8'h13}}, {16{8'h2D}}, "R5 mul8");
    send(4'd2, 2'd1, {8{16'h1234}}, {8{16'h0F0F}}, "R5 mul16");
    send(4'd2, 2'd2, {4{32'hDEAD_BEEF}}, {4{32'h1234_5679}}, "R5 mul32");
    // R6
    send(4'd3, 2'd0, 128'h00FF_1122_3344_5566_7788_99AA_BBCC_DDEE, 128'h00FE_1122_3345_5566_7788_99AB_BBCC_DDEE, "R6 eq8");
    send(4'd3, 2'd2, 128'hAAAA_0000_BBBB_1111_CCCC_2222_DDDD_3333, 128'hAAAA_0000_BBBB_1112_CCCC_2222_DDDD_3330, "R6 eq32");
    // R7
    send(4'd4, 2'd1, 128'h0001_0002_0100_8000_0000_F0F0_0F0F_FFFF, 128'h0001_0001_0100_8000_FFFF_0F0F_0F00_0000, "R7 tst16");
    // R8
    send(4'd5, 2'd0, 128'h80FF_7F01_8081_0002_FE00_7080_9010_2030, '0, "R8 abs8");
    send(4'd5, 2'd1, {4{16'h8000, 16'hFFF6}}, '0, "R8 abs16");
    send(4'd5, 2'd2, {32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0}, '1, "R8 abs32");
    send(4'd6, 2'd0, {8{8'h80, 8'h05}}, '0, "R8 neg8");
    send(4'd6, 2'd2, {32'h8000_0000, 32'h1, 32'hFFFF_FFFE, 32'h0}, '0, "R8 neg32");
    // R9 size code ignored
    send(4'd7, 2'd3, {4{32'hC0A0_0001}}, '0, "R9 fabs");
    send(4'd8, 2'd0, {32'h3F80_0000, 32'hBF80_0000, 32'h0, 32'hFFFF_FFFF}, '0, "R9 fneg");
    // R10
    send(4'd9, 2'd3, 128'h0123_4567_89AB_CDEF_0F0F_F0F0_1234_5678, '0, "R10 not");
    send(4'd10, 2'd3, 128'hFFFF_0000_AAAA_5555_1234_5678_9ABC_DEF0, 128'h0F0F_F0F0_5555_5555_FFFF_0000_0000_FFFF, "R10 xor");
    // R11
    send(4'd0, 2'd3, '1, '1, "R11 add size3");
    send(4'd5, 2'd3, '1, '0, "R11 abs size3");
    // R12
    send(4'd12, 2'd1, '1, '1, "R12 op12");
    send(4'd15, 2'd0, '1, '1, "R12 op15");
    send(4'd10, 2'd1, '1, '0, "R12 legal after illegal");
    @(negedge clk); in_valid = 1'b0; op_sel = 4'd0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    // R2 hold while idle
    checks++;
    if (out_valid !== 1'b0 || {illegal, result} !== last_exp || exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 idle hold actual v=%0b res=%h expected v=0 res=%h", out_valid, result, last_exp[127:0]);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule